// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is an 8-bit timer that counts from 0 up to 255 and back down to 0, and drives one pulse-width-modulated output from it. The output is centred on the zero point of the count. A clock-enable divider in front of the counter sets the rate at which the count moves. The divide ratio is 1, 8, 64, 256 or 1024 system clocks per count step, or the divider can stop the count. One full up-and-down period lasts 510 count steps.

A duty threshold is written into a holding register. It takes effect only when the count reaches its top value, so that each period uses one threshold throughout. While the count rises, the output drops when the count meets the threshold. While the count falls, the output rises when the count meets the threshold. A threshold of 0 keeps the output low and a threshold of 255 keeps it high. At the top of the count the output is driven low whenever the threshold is below 255, even if no match took place on the way up. This keeps the waveform symmetric when the threshold has just changed. An invert control complements the output level, and an enable gates the pin. Two sticky flags report when the count returns to zero and when it meets the threshold.

Top module: `pcpwm_timer`

## Requirements
- R1: `div_sel` picks the count rate: 1 gives a step every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. Codes 0, 6 and 7 stop the count. The divider is a free-running 10-bit counter that is cleared by reset. With a divide ratio of N, a step occurs on the clock edge where the divider's low log2(N) bits are all ones.
- R2: After reset the count is 0. It rises one per step to 255, then falls one per step to 0, and then rises again. Neither end value is repeated, so a period lasts 510 steps.
- R3: `duty_wr` stores `duty_in` in a holding register. The holding register is copied into the active threshold on the step that brings the count to 255. A write made on that same clock takes effect one period later.
- R4: With an active threshold from 1 to 254, the output level goes low on the step where a rising count equals the threshold. It goes high on the step where a falling count equals the threshold. Between these events it holds its level.
- R5: An active threshold of 0 keeps the output level low.
- R6: An active threshold of 255 keeps the output level high.
- R7: On the step that brings the count to 255, and while the count stays at 255, the output level is low whenever the active threshold is below 255. This holds whether or not a rising match occurred.
- R8: When `pol_inv` is 1, `pwm_out` is the complement of the level described in R4 to R7.
- R9: When `pin_en` is 0, `pwm_out` is 0.
- R10: `zero_flag` goes to 1 on the step that brings the count to 0. It stays at 1 until a clock with `zero_clr` high. If a set and a clear fall on the same clock, the set wins.
- R11: `match_flag` goes to 1 on any step after which the count equals the active threshold. It stays at 1 until a clock with `match_clr` high. If a set and a clear fall on the same clock, the set wins.
- R12: Synchronous reset (`rst` high on a clock edge) gives: count 0, direction up, holding and active thresholds 0, level low, both flags 0 and divider 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 3 | Count-rate select (see R1) |
| duty_wr | input | 1 | Write strobe for the holding threshold |
| duty_in | input | 8 | Threshold value to store |
| pol_inv | input | 1 | Invert output polarity |
| pin_en | input | 1 | Output enable; 0 forces `pwm_out` low |
| zero_clr | input | 1 | Clear `zero_flag` |
| match_clr | input | 1 | Clear `match_flag` |
| pwm_out | output | 1 | PWM output |
| count | output | 8 | Current count value |
| zero_flag | output | 1 | Sticky flag: count returned to 0 |
| match_flag | output | 1 | Sticky flag: count met the threshold |

## Verification
A wrong direction bit or divider phase shows on `count` at the very next step, so a per-clock comparison of the count catches it within one divide period. A fault in the threshold transfer or the level logic stays hidden until the count crosses the threshold or reaches 255. For that reason each threshold is held for at least one full 510-step period, and the ends 0 and 255 are visited explicitly, including a change away from 255. Flag faults show on the clock of the set step, and the set-versus-clear collision is driven directly.

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   div_sel,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_in,
  input  logic         pol_inv,
  input  logic         pin_en,
  input  logic         zero_clr,
  input  logic         match_clr,
  output logic         pwm_out,
  output logic [W-1:0] count,
  output logic         zero_flag,
  output logic         match_flag
);
  localparam int PW = 10;
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic [PW-1:0] pre;
  logic          tick;
  logic          up, up_n;
  logic          lvl, lvl_n;
  logic [W-1:0]  cnt_n, hold, act, act_n;

  always_comb begin
    case (div_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  assign cnt_n = up ? count + 1'b1 : count - 1'b1;
  assign up_n  = (cnt_n == TOP) ? 1'b0 : (cnt_n == BOT) ? 1'b1 : up;
  assign act_n = (cnt_n == TOP) ? hold : act;

  always_comb begin
    if (act_n == BOT)        lvl_n = 1'b0;
    else if (act_n == TOP)   lvl_n = 1'b1;
    else if (cnt_n == TOP)   lvl_n = 1'b0;
    else if (cnt_n == act_n) lvl_n = ~up;
    else                     lvl_n = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre        <= '0;
      count      <= BOT;
      up         <= 1'b1;
      hold       <= BOT;
      act        <= BOT;
      lvl        <= 1'b0;
      zero_flag  <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      pre <= pre + 1'b1;
      if (duty_wr) hold <= duty_in;
      if (tick) begin
        count <= cnt_n;
        up    <= up_n;
        act   <= act_n;
        lvl   <= lvl_n;
      end
      zero_flag  <= (zero_flag & ~zero_clr) | (tick & (cnt_n == BOT));
      match_flag <= (match_flag & ~match_clr) | (tick & (cnt_n == act_n));
    end
  end

  assign pwm_out = pin_en & (lvl ^ pol_inv);
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] div_sel,
  input logic       pin_en,
  input logic       pol_inv,
  input logic       pwm_out,
  input logic [7:0] count,
  input logic       zero_flag,
  input logic       zero_clr,
  input logic [7:0] act
);
  p_stop_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (div_sel == 3'd0 || div_sel == 3'd6 || div_sel == 3'd7) |=> $stable(count));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) || count == $past(count) + 8'd1 || count == $past(count) - 8'd1));

  p_zero_duty_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_en && act == 8'd0) |-> (pwm_out == pol_inv));

  p_full_duty_r6: assert property (@(posedge clk) disable iff (rst)
    (pin_en && act == 8'hFF) |-> (pwm_out == !pol_inv));

  p_top_low_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_en && count == 8'hFF && act != 8'hFF) |-> (pwm_out == pol_inv));

  p_pin_off_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_en) |-> !pwm_out);

  p_zero_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (zero_flag && !zero_clr) |=> zero_flag);
endmodule

bind pcpwm_timer pcpwm_timer_chk u_chk (
  .clk(clk), .rst(rst), .div_sel(div_sel), .pin_en(pin_en), .pol_inv(pol_inv),
  .pwm_out(pwm_out), .count(count), .zero_flag(zero_flag), .zero_clr(zero_clr),
  .act(act)
);

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;
  logic clk = 0;
  logic rst = 1;
  logic [2:0] div_sel = 3'd1;
  logic duty_wr = 0;
  logic [7:0] duty_in = 0;
  logic pol_inv = 0, pin_en = 1, zero_clr = 0, match_clr = 0;
  logic pwm_out, zero_flag, match_flag;
  logic [7:0] count;

  int checks = 0, fails = 0;
  int m_pre, m_cnt, m_up, m_hold, m_act, m_lvl, m_zf, m_mf;

  always #5 clk = ~clk;

  pcpwm_timer i_pcpwm_timer (
    .clk(clk), .rst(rst), .div_sel(div_sel), .duty_wr(duty_wr), .duty_in(duty_in),
    .pol_inv(pol_inv), .pin_en(pin_en), .zero_clr(zero_clr), .match_clr(match_clr),
    .pwm_out(pwm_out), .count(count), .zero_flag(zero_flag), .match_flag(match_flag)
  );

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int n, nc, t, step_up;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_up = 1; m_hold = 0; m_act = 0;
      m_lvl = 0; m_zf = 0; m_mf = 0;
      return;
    end
    n = divisor(div_sel);
    t = (n != 0) && ((m_pre % n) == n - 1);
    m_pre = (m_pre + 1) % 1024;
    nc = m_cnt;
    if (t) begin
      step_up = m_up;
      nc = m_up ? m_cnt + 1 : m_cnt - 1;
      if (nc == 255) begin m_up = 0; m_act = m_hold; end
      if (nc == 0) m_up = 1;
      m_cnt = nc;
      if (m_act == 0) m_lvl = 0;
      else if (m_act == 255) m_lvl = 1;
      else m_lvl = step_up ? (nc < m_act) : (nc <= m_act);
    end
    m_zf = (m_zf && !zero_clr) || (t && nc == 0);
    m_mf = (m_mf && !match_clr) || (t && nc == m_act);
    if (duty_wr) m_hold = duty_in;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d (count model %0d)", tag, got, exp, m_cnt);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      int exp_pwm;
      string ptag;
      model_step();
      @(posedge clk);
      #1;
      exp_pwm = pin_en ? (m_lvl ^ pol_inv) : 0;
      if (!pin_en) ptag = "R9 pin disabled";
      else if (m_act == 0) ptag = "R5 zero duty";
      else if (m_act == 255) ptag = "R6 full duty";
      else if (m_cnt == 255) ptag = "R7 forced low at top";
      else if (pol_inv) ptag = "R8 inverted level";
      else ptag = "R4 match edges (R3 load)";
      chk(ptag, pwm_out, exp_pwm);
      chk(div_sel == 3'd1 ? "R2 count sequence" : "R1 divided count", count, m_cnt);
      chk("R10 zero flag", zero_flag, m_zf);
      chk("R11 match flag", match_flag, m_mf);
    end
  endtask

  task automatic write_duty(input int v);
    duty_wr = 1; duty_in = 8'(v);
    cyc(1);
    duty_wr = 0;
  endtask

  task automatic run_to_count(input int v);
    for (int i = 0; i < 2000 && m_cnt != v; i++) cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    chk("R12 reset count", count, 0);
    chk("R12 reset pwm", pwm_out, 0);
    chk("R12 reset zero flag", zero_flag, 0);
    chk("R12 reset match flag", match_flag, 0);

    write_duty(100);
    cyc(1100);
    write_duty(0);
    cyc(1100);
    write_duty(255);
    cyc(1100);
    write_duty(50);
    run_to_count(255);
    chk("R7 level low at top after leaving 255", pwm_out, 0);
    cyc(600);

    run_to_count(200);
    write_duty(20);
    cyc(1100);
    write_duty(1);
    cyc(600);
    write_duty(254);
    cyc(1100);

    run_to_count(254);
    if (m_up == 1) begin
      write_duty(77);
      chk("R3 write on top step deferred", count, 255);
    end
    cyc(1100);

    pol_inv = 1;
    cyc(700);
    pin_en = 0;
    cyc(300);
    pin_en = 1; pol_inv = 0;

    zero_clr = 1; match_clr = 1;
    cyc(3);
    zero_clr = 0; match_clr = 0;
    cyc(40);
    run_to_count(1);
    zero_clr = 1;
    run_to_count(0);
    chk("R10 set beats clear", zero_flag, 1);
    zero_clr = 0;
    cyc(20);

    div_sel = 3'd2; cyc(600);
    div_sel = 3'd3; cyc(1500);
    div_sel = 3'd0; cyc(100);
    div_sel = 3'd7; cyc(100);
    div_sel = 3'd6; cyc(100);
    div_sel = 3'd4; cyc(1600);
    div_sel = 3'd5; cyc(3200);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule